// File: doc/BRIEF.md
# Interrupt Master Enable and Halt Controller

This block sits beside the sequencer of a small CPU core and owns two pieces of state: the master switch that allows interrupts to be taken, and the low-power halted condition. The sequencer raises `instrEnd` in the cycle an instruction completes. Together with it, the sequencer raises one of four strobes when that instruction was disable-interrupts, enable-interrupts, return-from-interrupt or halt. The block also watches the per-source enable mask and the per-source request flags and reports whether any source is both enabled and requesting.

When the master switch is on and a source is pending, the block raises a one-cycle dispatch request. This happens either at an instruction end or while halted. The same request turns the switch off. The enable instruction only takes effect after the following instruction has completed. Return-from-interrupt takes effect at once. Halt has three outcomes:
- With the switch on, the core sleeps until a dispatch.
- With the switch off and nothing pending, the core sleeps until a source becomes pending and then simply resumes.
- With the switch off and a source already pending, the core does not sleep. Instead it gets a one-cycle pulse telling the fetch logic not to advance the program counter, so the byte after the halt is fetched twice.

Top module: `imeHaltCtrl`

## Requirements
- R1: After reset, `ime`, `halted`, `skipInc` and `irqTake` are all 0.
- R2: A disable strobe at an instruction end makes `ime` 0 from the next cycle. It also cancels an enable that has not yet taken effect, so `ime` stays 0 after the following instruction end.
- R3: An enable strobe at an instruction end leaves `ime` unchanged in the next cycle. `ime` becomes 1 in the cycle after the next instruction end.
- R4: A return-from-interrupt strobe at an instruction end makes `ime` 1 from the next cycle.
- R5: `irqPending` is 1 exactly when the bitwise AND of `ieMask` and `ifFlags` is non-zero, in the same cycle, with no register in the path.
- R6: `irqTake` is 1 in a cycle where `ime` is 1, `irqPending` is 1, and either `instrEnd` is 1 or `halted` is 1. In the cycle after `irqTake`, `ime` is 0.
- R7: A halt strobe with `ime` 1 and nothing pending sets `halted` from the next cycle. In the first cycle with a pending source, `irqTake` pulses, and both `halted` and `ime` are 0 in the following cycle. A halt strobe with `ime` 1 and a source already pending dispatches at once and does not set `halted`.
- R8: A halt strobe with `ime` 0 and nothing pending sets `halted`. When a source becomes pending, `halted` is 0 in the next cycle and `irqTake` stays 0.
- R9: A halt strobe with `ime` 0 and a source pending leaves `halted` at 0. It makes `skipInc` 1 for exactly the one cycle after that instruction end.
- R10: Instruction strobes have no effect in a cycle where `instrEnd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrEnd | input | 1 | An instruction completes in this cycle |
| diStb | input | 1 | The completing instruction is disable-interrupts |
| eiStb | input | 1 | The completing instruction is enable-interrupts |
| retiStb | input | 1 | The completing instruction is return-from-interrupt |
| haltStb | input | 1 | The completing instruction is halt |
| ieMask | input | NUM_SRC | Per-source interrupt enable bits |
| ifFlags | input | NUM_SRC | Per-source interrupt request flags |
| ime | output | 1 | Master interrupt enable |
| halted | output | 1 | Core is in the halted state |
| irqPending | output | 1 | Some source is both enabled and requesting |
| irqTake | output | 1 | One-cycle dispatch request |
| skipInc | output | 1 | Do not advance the program counter on this opcode fetch |

## Verification
`irqPending` and `irqTake` are combinational, so the bench reads them shortly after driving inputs in the same cycle. `ime`, `halted` and `skipInc` each sit behind one register, so they are read one clock after the stimulus that changes them. For the enable strobe, the bench reads `ime` once after the enable itself and again after the next instruction end. This tells the one-instruction delay apart from an immediate enable. The bench drives inputs on the falling edge and samples either 1 ns later (for combinational outputs) or on the following falling edge (for registered ones), so no result depends on ordering at the rising edge.

// File: rtl/imeHaltPkg.sv
package imeHaltPkg;
  // Strobes from the decision logic to the state registers.
  typedef struct packed {
    logic boundary;   // instruction end while running
    logic take;       // dispatch this cycle
    logic setIme;
    logic clrIme;
    logic armEi;      // start a delayed enable
    logic enterHalt;
    logic leaveHalt;
    logic skipFetch;  // duplicated-fetch case
  } ctlStrobes_t;
endpackage

// File: rtl/imeHaltData.sv
module imeHaltData
  import imeHaltPkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        st,
  input  logic [NUM_SRC-1:0] ieMask,
  input  logic [NUM_SRC-1:0] ifFlags,
  output logic               imeQ,
  output logic               eiPendQ,
  output logic               haltedQ,
  output logic               skipQ,
  output logic               pending
);
  logic [NUM_SRC-1:0] srcLive;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcLive[i] = ieMask[i] & ifFlags[i];
  end
  assign pending = |srcLive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imeQ    <= 1'b0;
      eiPendQ <= 1'b0;
      haltedQ <= 1'b0;
      skipQ   <= 1'b0;
    end else begin
      if (st.clrIme)      imeQ <= 1'b0;
      else if (st.setIme) imeQ <= 1'b1;

      if (st.boundary)    eiPendQ <= st.armEi;
      else if (st.take)   eiPendQ <= 1'b0;

      if (st.enterHalt)      haltedQ <= 1'b1;
      else if (st.leaveHalt) haltedQ <= 1'b0;

      skipQ <= st.skipFetch;
    end
  end
endmodule

// File: rtl/imeHaltCtl.sv
module imeHaltCtl
  import imeHaltPkg::*;
(
  input  logic        instrEnd,
  input  logic        diStb,
  input  logic        eiStb,
  input  logic        retiStb,
  input  logic        haltStb,
  input  logic        imeQ,
  input  logic        eiPendQ,
  input  logic        haltedQ,
  input  logic        pending,
  output ctlStrobes_t st
);
  logic bnd;
  logic take;

  always_comb begin
    bnd  = instrEnd & ~haltedQ;
    take = imeQ & pending & (bnd | haltedQ);

    st.boundary  = bnd;
    st.take      = take;
    st.clrIme    = (bnd & diStb) | take;
    st.setIme    = ~st.clrIme & bnd & (retiStb | eiPendQ);
    st.armEi     = eiStb & ~diStb & ~take;
    st.enterHalt = bnd & haltStb & ~pending & ~take;
    st.leaveHalt = haltedQ & pending;
    st.skipFetch = bnd & haltStb & pending & ~imeQ;
  end
endmodule

// File: rtl/imeHaltCtrl.sv
module imeHaltCtrl
  import imeHaltPkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instrEnd,
  input  logic               diStb,
  input  logic               eiStb,
  input  logic               retiStb,
  input  logic               haltStb,
  input  logic [NUM_SRC-1:0] ieMask,
  input  logic [NUM_SRC-1:0] ifFlags,
  output logic               ime,
  output logic               halted,
  output logic               irqPending,
  output logic               irqTake,
  output logic               skipInc
);
  ctlStrobes_t st;
  logic eiPendQ;

  imeHaltCtl u_ctl (
    .instrEnd(instrEnd), .diStb(diStb), .eiStb(eiStb), .retiStb(retiStb),
    .haltStb(haltStb), .imeQ(ime), .eiPendQ(eiPendQ), .haltedQ(halted),
    .pending(irqPending), .st(st)
  );

  imeHaltData #(.NUM_SRC(NUM_SRC)) u_data (
    .clk(clk), .rst_n(rst_n), .st(st), .ieMask(ieMask), .ifFlags(ifFlags),
    .imeQ(ime), .eiPendQ(eiPendQ), .haltedQ(halted), .skipQ(skipInc),
    .pending(irqPending)
  );

  assign irqTake = st.take;
endmodule

// File: rtl/imeHaltCtrl_checker.sv
module imeHaltCtrl_checker (
  input logic clk,
  input logic rst_n,
  input logic instrEnd,
  input logic diStb,
  input logic retiStb,
  input logic ime,
  input logic halted,
  input logic irqPending,
  input logic irqTake,
  input logic skipInc
);
  a_r2_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    instrEnd && !halted && diStb |=> !ime);

  a_r4_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    instrEnd && !halted && retiStb && !diStb && !irqTake |=> ime);

  a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |=> !ime);

  a_r6_take_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> ime && irqPending);

  a_r7_wake_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    halted && irqPending |=> !halted);

  a_r8_no_take_ime_clear: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !ime |-> !irqTake);

  a_r9_skip_single: assert property (@(posedge clk) disable iff (!rst_n)
    skipInc |=> !skipInc);

  a_r9_skip_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
    skipInc |-> !halted);
endmodule

bind imeHaltCtrl imeHaltCtrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .instrEnd(instrEnd), .diStb(diStb),
  .retiStb(retiStb), .ime(ime), .halted(halted), .irqPending(irqPending),
  .irqTake(irqTake), .skipInc(skipInc)
);

// File: tb/imeHaltCtrl_bench.sv
module imeHaltCtrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instrEnd = 1'b0, diStb = 1'b0, eiStb = 1'b0, retiStb = 1'b0, haltStb = 1'b0;
  logic [NUM_SRC-1:0] ieMask = '0, ifFlags = '0;
  logic ime, halted, irqPending, irqTake, skipInc;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imeHaltCtrl #(.NUM_SRC(NUM_SRC)) u_imeHaltCtrl (
    .clk(clk), .rst_n(rst_n), .instrEnd(instrEnd), .diStb(diStb), .eiStb(eiStb),
    .retiStb(retiStb), .haltStb(haltStb), .ieMask(ieMask), .ifFlags(ifFlags),
    .ime(ime), .halted(halted), .irqPending(irqPending), .irqTake(irqTake),
    .skipInc(skipInc)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic doInstr(input logic d, input logic e, input logic r,
                         input logic h, output logic tk);
    instrEnd = 1'b1; diStb = d; eiStb = e; retiStb = r; haltStb = h;
    #1 tk = irqTake;
    @(negedge clk);
    instrEnd = 1'b0; diStb = 1'b0; eiStb = 1'b0; retiStb = 1'b0; haltStb = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 ime", ime, 1'b0);
    chk("R1 halted", halted, 1'b0);
    chk("R1 skipInc", skipInc, 1'b0);
    chk("R1 irqTake", irqTake, 1'b0);
  endtask

  task automatic testPending();
    ieMask = 8'h05; ifFlags = 8'h02; #1;
    chk("R5 disjoint", irqPending, 1'b0);
    ifFlags = 8'h04; #1;
    chk("R5 overlap", irqPending, 1'b1);
    ieMask = 8'h80; ifFlags = 8'h80; #1;
    chk("R5 top bit", irqPending, 1'b1);
    ieMask = '0; ifFlags = '0;
    @(negedge clk);
  endtask

  task automatic testEiDelay();
    logic tk;
    doInstr(0, 1, 0, 0, tk);
    chk("R3 ime after ei", ime, 1'b0);
    doInstr(0, 0, 0, 0, tk);
    chk("R3 ime after next", ime, 1'b1);
    ieMask = 8'h01; ifFlags = 8'h01;
    doInstr(0, 0, 0, 0, tk);
    chk("R6 take at boundary", tk, 1'b1);
    chk("R6 ime cleared", ime, 1'b0);
    ieMask = '0; ifFlags = '0;
  endtask

  task automatic testRetiDi();
    logic tk;
    doInstr(0, 0, 1, 0, tk);
    chk("R4 reti immediate", ime, 1'b1);
    doInstr(1, 0, 0, 0, tk);
    chk("R2 di clears", ime, 1'b0);
    doInstr(0, 1, 0, 0, tk);
    doInstr(1, 0, 0, 0, tk);
    chk("R2 di cancels ei", ime, 1'b0);
    doInstr(0, 0, 0, 0, tk);
    chk("R2 stays clear", ime, 1'b0);
  endtask

  task automatic testNoBoundary();
    logic tk;
    doInstr(0, 0, 1, 0, tk);
    diStb = 1'b1; @(negedge clk); diStb = 1'b0;
    chk("R10 di ignored", ime, 1'b1);
    haltStb = 1'b1; @(negedge clk); haltStb = 1'b0;
    chk("R10 halt ignored", halted, 1'b0);
    doInstr(1, 0, 0, 0, tk);
    eiStb = 1'b1; @(negedge clk); eiStb = 1'b0;
    doInstr(0, 0, 0, 0, tk);
    chk("R10 ei ignored", ime, 1'b0);
  endtask

  task automatic testHaltImeSet();
    logic tk;
    doInstr(0, 0, 1, 0, tk);
    doInstr(0, 0, 0, 1, tk);
    chk("R7 halted", halted, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 still halted", halted, 1'b1);
    ieMask = 8'h10; ifFlags = 8'h10; #1;
    chk("R7 take while halted", irqTake, 1'b1);
    @(negedge clk);
    chk("R7 woke", halted, 1'b0);
    chk("R7 ime off", ime, 1'b0);
    // halt with ime set and already pending: dispatch, no sleep
    doInstr(0, 0, 1, 0, tk);
    doInstr(0, 0, 0, 1, tk);
    chk("R7 immediate take", tk, 1'b1);
    chk("R7 no halt", halted, 1'b0);
    ieMask = '0; ifFlags = '0;
  endtask

  task automatic testHaltImeClear();
    logic tk;
    doInstr(0, 0, 0, 1, tk);
    chk("R8 halted", halted, 1'b1);
    ieMask = 8'h02; ifFlags = 8'h02; #1;
    chk("R8 no take", irqTake, 1'b0);
    @(negedge clk);
    chk("R8 woke", halted, 1'b0);
    chk("R8 ime still off", ime, 1'b0);
    chk("R8 no skip", skipInc, 1'b0);
  endtask

  task automatic testHaltBug();
    logic tk;
    ieMask = 8'h40; ifFlags = 8'h40;
    doInstr(0, 0, 0, 1, tk);
    chk("R9 no take", tk, 1'b0);
    chk("R9 not halted", halted, 1'b0);
    chk("R9 skip pulse", skipInc, 1'b1);
    @(negedge clk);
    chk("R9 skip ends", skipInc, 1'b0);
    ieMask = '0; ifFlags = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPending();
    testEiDelay();
    testRetiDi();
    testNoBoundary();
    testHaltImeSet();
    testHaltImeClear();
    testHaltBug();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule